// File: doc/BRIEF.md
# Hardware Cursor Overlay Compositor

This block is the last per-pixel stage in front of a display output. Each cycle it takes a scan position, the palette-mapped colour for that position, and a direct 24-bit colour for that position. It picks the underlying colour from these and then lays a 32x32 hardware cursor on top. The cursor has two planes. A mask plane decides where the cursor is opaque. An image plane decides which of two overlay colours is shown there. The overlay colours come from the palette block, which is outside this block, along with timing generation.

Software programs the cursor over a 32-bit register bus. The programmable state is the position word, 32 mask rows, 32 image rows and a general-purpose misc word. Writes land in shadow copies, and the compositor uses those copies only after the next frame-start pulse, so the cursor never changes part way through a frame. Cursor x comes out of reset parked at 0xF000, which keeps the cursor hidden until software places it.

Top module: `cursor_overlay`

## Requirements
- R1: A pixel presented with `pix_valid` high before clock edge k appears on `out_rgb` with `out_valid` high after edge k+1. This is a latency of two cycles, and back-to-back pixels stream at one per cycle.
- R2: When `deep_mode` is low, the underlying colour is `idx_rgb`, whatever the value of `ctl_mode`.
- R3: When `deep_mode` is high, the underlying colour is `direct_rgb` if either bit of `ctl_mode` is set. `ctl_mode` carries bits 25:24 of the pixel's control word. When both bits are clear, the underlying colour is `idx_rgb`.
- R4: The position register sits at offset 0x8FC. It holds cursor x in bits 31:16 and cursor y in bits 15:0. The cursor covers columns x to x+31 and rows y to y+31, and no pixel outside that window is changed.
- R5: Cursor row r (0 to 31) of the mask plane is written at 0x900+4r, and row r of the image plane at 0x980+4r. Within a row word, bit 31 is the leftmost cursor column (column 0) and bit 0 is column 31.
- R6: Inside the window, a set mask bit shows `ovl_fg` when the image bit is set and `ovl_bg` when it is clear. A clear mask bit shows the underlying colour.
- R7: The cursor is drawn only while cursor x is less than `scr_width`. With cursor x equal to `scr_width`, the window shows the underlying colour.
- R8: After reset, `out_valid` is low, cursor x is 0xF000, cursor y and all plane rows are zero, the misc word is zero, and no pixel is overlaid.
- R9: Reading offset 0x818 returns the stored misc word with bit 25 forced to one. Every other offset reads as zero.
- R10: Register writes change only shadow state. The shadow state is copied into the active state on the edge where `frame_start` is high. A write on that same edge takes effect only at the following frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| frame_start | input | 1 | One-cycle pulse that loads shadow state into active state |
| scr_width | input | 16 | Visible screen width in pixels |
| pix_valid | input | 1 | A pixel is presented this cycle |
| scan_x | input | 16 | Scan column |
| scan_y | input | 16 | Scan row |
| deep_mode | input | 1 | 24-bit display mode |
| ctl_mode | input | 2 | Bits 25:24 of the pixel's control word |
| idx_rgb | input | 24 | Palette-mapped colour of the pixel |
| direct_rgb | input | 24 | Direct 24-bit colour of the pixel |
| ovl_bg | input | 24 | Overlay colour for mask set, image clear |
| ovl_fg | input | 24 | Overlay colour for mask set, image set |
| out_valid | output | 1 | `out_rgb` holds a pixel |
| out_rgb | output | 24 | Composited colour |

## Verification
The assertions check four things on every cycle: the two-cycle valid latency, the misc read-back with its forced bit, the rule that active cursor state moves only on a frame-start edge and then equals the shadow, and that a cursor parked at or past the screen width never produces a hit. Only the bench scenarios can show the colour results. These are the bit-31-leftmost mapping, the foreground and background choice, the exact window edges at x+31 and y+31, the direct versus palette selection, and a write that lands on a frame-start edge being deferred a full frame.

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter int PW = 16,
  parameter int CW = 24,
  parameter int CUR = 32,
  parameter int FORCE_BIT = 25,
  parameter logic [AW-1:0] MISC_ADR = 12'h818,
  parameter logic [AW-1:0] POS_ADR  = 12'h8FC,
  parameter logic [AW-1:0] MASK_ADR = 12'h900,
  parameter logic [AW-1:0] IMG_ADR  = 12'h980,
  parameter logic [PW-1:0] PARK_X   = 16'hF000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          frame_start,
  input  logic [PW-1:0] scr_width,
  input  logic          pix_valid,
  input  logic [PW-1:0] scan_x,
  input  logic [PW-1:0] scan_y,
  input  logic          deep_mode,
  input  logic [1:0]    ctl_mode,
  input  logic [CW-1:0] idx_rgb,
  input  logic [CW-1:0] direct_rgb,
  input  logic [CW-1:0] ovl_bg,
  input  logic [CW-1:0] ovl_fg,
  output logic          out_valid,
  output logic [CW-1:0] out_rgb
);
  localparam int RB = $clog2(CUR);
  localparam int HI = RB + 2;

  logic [PW-1:0] sh_cx, sh_cy, act_cx, act_cy;
  logic [CUR-1:0] sh_mask [CUR];
  logic [CUR-1:0] sh_img  [CUR];
  logic [CUR-1:0] act_mask [CUR];
  logic [CUR-1:0] act_img  [CUR];
  logic [DW-1:0] misc;

  wire mask_sel = reg_addr[AW-1:HI] == MASK_ADR[AW-1:HI];
  wire img_sel  = reg_addr[AW-1:HI] == IMG_ADR[AW-1:HI];
  wire [RB-1:0] wrow = reg_addr[HI-1:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_cx <= PARK_X; sh_cy <= '0;
      act_cx <= PARK_X; act_cy <= '0;
      misc <= '0;
      for (int i = 0; i < CUR; i++) begin
        sh_mask[i] <= '0; sh_img[i] <= '0;
        act_mask[i] <= '0; act_img[i] <= '0;
      end
    end else begin
      if (frame_start) begin
        act_cx <= sh_cx; act_cy <= sh_cy;
        for (int i = 0; i < CUR; i++) begin
          act_mask[i] <= sh_mask[i];
          act_img[i]  <= sh_img[i];
        end
      end
      if (reg_we) begin
        if (reg_addr == POS_ADR) begin
          sh_cx <= reg_wdata[2*PW-1:PW];
          sh_cy <= reg_wdata[PW-1:0];
        end
        if (reg_addr == MISC_ADR) misc <= reg_wdata;
        if (mask_sel) sh_mask[wrow] <= reg_wdata[CUR-1:0];
        if (img_sel)  sh_img[wrow]  <= reg_wdata[CUR-1:0];
      end
    end
  end

  localparam logic [DW-1:0] FORCE = DW'(1) << FORCE_BIT;
  assign reg_rdata = (reg_addr == MISC_ADR) ? (misc | FORCE) : '0;

  wire [PW:0] dy = {1'b0, scan_y} - {1'b0, act_cy};
  wire [PW:0] dx = {1'b0, scan_x} - {1'b0, act_cx};
  wire row_in = ~dy[PW] && (dy[PW-1:RB] == '0);
  wire col_in = ~dx[PW] && (dx[PW-1:RB] == '0);
  wire [RB-1:0] rr = dy[RB-1:0];
  wire [RB-1:0] cc = RB'(CUR - 1) - dx[RB-1:0];
  wire hit = row_in && col_in && (act_cx < scr_width) && act_mask[rr][cc];
  wire [CW-1:0] base = (deep_mode && |ctl_mode) ? direct_rgb : idx_rgb;

  logic s1_v, s1_hit;
  logic [CW-1:0] s1_base, s1_ovl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_hit <= 1'b0; s1_base <= '0; s1_ovl <= '0;
      out_valid <= 1'b0; out_rgb <= '0;
    end else begin
      s1_v <= pix_valid;
      s1_hit <= pix_valid && hit;
      s1_base <= base;
      s1_ovl <= act_img[rr][cc] ? ovl_fg : ovl_bg;
      out_valid <= s1_v;
      out_rgb <= s1_hit ? s1_ovl : s1_base;
    end
  end
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter int PW = 16,
  parameter int FORCE_BIT = 25,
  parameter logic [AW-1:0] MISC_ADR = 12'h818
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_valid,
  input logic          out_valid,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_rdata,
  input logic          frame_start,
  input logic [PW-1:0] scr_width,
  input logic [PW-1:0] act_cx,
  input logic [PW-1:0] act_cy,
  input logic [PW-1:0] sh_cx,
  input logic [PW-1:0] sh_cy,
  input logic          s1_hit
);
  logic [1:0] age;
  logic [1:0] vhist;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age <= '0; vhist <= '0;
    end else begin
      if (age != 2'd2) age <= age + 2'd1;
      vhist <= {vhist[0], pix_valid};
    end
  end

  // R1
  latency_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (out_valid == vhist[1]));

  // R9
  misc_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == MISC_ADR) |-> reg_rdata[FORCE_BIT]);

  // R9
  other_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != MISC_ADR) |-> (reg_rdata == '0));

  // R10
  hold_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(act_cx) && $stable(act_cy)));

  // R10
  load_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (act_cx == $past(sh_cx) && act_cy == $past(sh_cy)));

  // R7
  clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && act_cx >= scr_width) |=> !s1_hit);
endmodule

bind cursor_overlay cursor_overlay_chk #(
  .AW(AW), .DW(DW), .PW(PW), .FORCE_BIT(FORCE_BIT), .MISC_ADR(MISC_ADR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .out_valid(out_valid),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .frame_start(frame_start),
  .scr_width(scr_width), .act_cx(act_cx), .act_cy(act_cy),
  .sh_cx(sh_cx), .sh_cy(sh_cy), .s1_hit(s1_hit)
);

// File: tb/sim_cursor_overlay.sv
module sim_cursor_overlay;
  logic clk = 0;
  always #2 clk = ~clk;

  logic rst_n, reg_we, frame_start, pix_valid, deep_mode;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [15:0] scr_width, scan_x, scan_y;
  logic [1:0] ctl_mode;
  logic [23:0] idx_rgb, direct_rgb, ovl_bg, ovl_fg, out_rgb;
  logic out_valid;

  cursor_overlay u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
    .scr_width(scr_width), .pix_valid(pix_valid), .scan_x(scan_x),
    .scan_y(scan_y), .deep_mode(deep_mode), .ctl_mode(ctl_mode),
    .idx_rgb(idx_rgb), .direct_rgb(direct_rgb), .ovl_bg(ovl_bg),
    .ovl_fg(ovl_fg), .out_valid(out_valid), .out_rgb(out_rgb)
  );

  int checks = 0, fails = 0;
  logic [23:0] exp_q[$];
  string tag_q[$];

  int sh_cx, sh_cy, m_cx, m_cy;
  logic [31:0] sh_m[32], sh_i[32], m_m[32], m_i[32];

  function automatic logic [23:0] expect_col(int x, int y, logic dp,
      logic [1:0] cm, logic [23:0] ix, logic [23:0] dr);
    logic [23:0] b;
    b = (dp && cm != 2'b00) ? dr : ix;
    if (m_cx < int'(scr_width) && y >= m_cy && y < m_cy + 32 &&
        x >= m_cx && x < m_cx + 32) begin
      if (m_m[y - m_cy][31 - (x - m_cx)])
        return m_i[y - m_cy][31 - (x - m_cx)] ? ovl_fg : ovl_bg;
    end
    return b;
  endfunction

  task automatic pix(int x, int y, logic dp, logic [1:0] cm, string tag);
    @(negedge clk);
    reg_we = 0; frame_start = 0;
    pix_valid = 1; scan_x = 16'(x); scan_y = 16'(y);
    deep_mode = dp; ctl_mode = cm;
    idx_rgb = 24'h100000 + 24'(x) + 24'(y << 10);
    direct_rgb = 24'h800000 + 24'(x) + 24'(y << 10);
    exp_q.push_back(expect_col(x, y, dp, cm, idx_rgb, direct_rgb));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_valid = 0; reg_we = 0; frame_start = 0;
    end
  endtask

  task automatic model_wr(logic [11:0] a, logic [31:0] d);
    if (a == 12'h8FC) begin sh_cx = int'(d[31:16]); sh_cy = int'(d[15:0]); end
    if (a >= 12'h900 && a < 12'h980) sh_m[(a - 12'h900) >> 2] = d;
    if (a >= 12'h980 && a < 12'hA00) sh_i[(a - 12'h980) >> 2] = d;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    pix_valid = 0; frame_start = 0;
    reg_we = 1; reg_addr = a; reg_wdata = d;
    model_wr(a, d);
  endtask

  task automatic model_frame();
    m_cx = sh_cx; m_cy = sh_cy;
    for (int i = 0; i < 32; i++) begin m_m[i] = sh_m[i]; m_i[i] = sh_i[i]; end
  endtask

  task automatic frame();
    @(negedge clk);
    pix_valid = 0; reg_we = 0; frame_start = 1;
    model_frame();
  endtask

  task automatic frame_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    pix_valid = 0; frame_start = 1;
    reg_we = 1; reg_addr = a; reg_wdata = d;
    model_frame();
    model_wr(a, d);
  endtask

  task automatic rd_chk(logic [11:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    pix_valid = 0; reg_we = 0; frame_start = 0; reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== e) begin
      fails++;
      $display("FAIL %s: read %h got %h expected %h", tag, a, reg_rdata, e);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R1: unexpected output got %h expected none", out_rgb);
      end else begin
        logic [23:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (out_rgb !== e) begin
          fails++;
          $display("FAIL %s: got %h expected %h", t, out_rgb, e);
        end
      end
    end
  end

  bit done = 0;
  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reg_we = 0; frame_start = 0; pix_valid = 0; deep_mode = 0;
    reg_addr = 0; reg_wdata = 0; scr_width = 16'd640; scan_x = 0; scan_y = 0;
    ctl_mode = 0; idx_rgb = 0; direct_rgb = 0;
    ovl_bg = 24'h0A0B0C; ovl_fg = 24'hF0F0F0;
    sh_cx = 16'hF000; sh_cy = 0;
    for (int i = 0; i < 32; i++) begin sh_m[i] = 0; sh_i[i] = 0; end
    model_frame();
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R8: out_valid got %b expected 0", out_valid);
    end
    rd_chk(12'h818, 32'h0200_0000, "R8 R9 misc reset");
    rd_chk(12'h8FC, 32'h0, "R9 position not readable");

    pix(0, 0, 0, 2'b00, "R8 parked cursor");
    pix(5, 5, 0, 2'b11, "R2 pseudocolour ignores ctl");
    pix(6, 5, 1, 2'b01, "R3 direct bit24");
    pix(7, 5, 1, 2'b10, "R3 direct bit25");
    pix(8, 5, 1, 2'b11, "R3 direct both");
    pix(9, 5, 1, 2'b00, "R3 palette when clear");
    idle(3);

    wr(12'h8FC, {16'd10, 16'd20});
    wr(12'h900, 32'h8000_0001);
    wr(12'h980, 32'h8000_0000);
    wr(12'h97C, 32'hFFFF_FFFF);
    wr(12'h9FC, 32'h0000_FFFF);
    pix(10, 20, 0, 2'b00, "R10 shadow not yet active");
    idle(3);
    frame();
    pix(10, 20, 0, 2'b00, "R6 R5 fg at col0");
    pix(41, 20, 0, 2'b00, "R6 R5 bg at col31");
    pix(11, 20, 0, 2'b00, "R6 mask clear underlying");
    pix(11, 20, 1, 2'b01, "R6 R3 mask clear direct");
    pix(10, 20, 1, 2'b01, "R6 fg over direct");
    pix(9, 20, 0, 2'b00, "R4 left of window");
    pix(42, 20, 0, 2'b00, "R4 right of window");
    pix(10, 19, 0, 2'b00, "R4 above window");
    pix(10, 51, 0, 2'b00, "R4 R5 last row bg");
    pix(41, 51, 0, 2'b00, "R4 R5 last row fg");
    pix(10, 52, 0, 2'b00, "R4 below window");
    idle(3);

    frame_wr(12'h8FC, {16'd200, 16'd200});
    pix(10, 20, 0, 2'b00, "R10 write on frame edge deferred");
    idle(3);
    frame();
    pix(10, 20, 0, 2'b00, "R10 old position gone");
    pix(200, 200, 0, 2'b00, "R4 moved cursor");
    idle(3);

    scr_width = 16'd201;
    pix(200, 200, 0, 2'b00, "R7 x below width drawn");
    idle(3);
    scr_width = 16'd200;
    pix(200, 200, 0, 2'b00, "R7 x equal width clipped");
    idle(3);
    scr_width = 16'd640;
    for (int x = 195; x < 240; x++) pix(x, 200, x[0], 2'b01, "R1 streaming row");
    for (int x = 195; x < 240; x++) pix(x, 231, 0, 2'b00, "R1 R6 streaming last row");
    idle(4);

    wr(12'h818, 32'h0000_0012);
    rd_chk(12'h818, 32'h0200_0012, "R9 misc forced bit");
    wr(12'h818, 32'hFFFF_FFFF);
    rd_chk(12'h818, 32'hFFFF_FFFF, "R9 misc all ones");
    rd_chk(12'h900, 32'h0, "R9 mask row not readable");
    idle(3);

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R1: pending outputs got %0d expected 0", exp_q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule